// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several software localities owns a shared secure-device register interface at any moment. Each locality sees its own copy of an ownership register, placed in an address window selected by the upper address bits: locality n is decoded at offset `n << OFS_W`, and the ownership register sits at offset 0 inside that window. Software asks for the interface by setting a request bit and gives it up by writing the active bit in its own window. Only one locality owns the interface at a time.

While a locality owns the interface, requests from the others are held as outstanding. The owner sees a pending flag, so it can decide to give the interface up. Release is always voluntary. When the interface is free, the highest-numbered locality with an outstanding request is granted. Every change of owner produces a one-cycle event for the interrupt logic. Until the device signals that initialization is complete, the registers read as not valid and all writes are discarded.

Reads are combinational from the address. Writes take effect on the clock edge where `bus_we` is high. The asynchronous reset is released through a two-stage synchronizer.

Top module: `loc_arbiter`

## Requirements
- R1: Bit 7 (valid) of every locality's ownership register reads 0 from reset until `init_done` has been seen high for at least one clock edge. After that it reads 1, even if `init_done` falls again.
- R2: Before initialization is complete, writes to the ownership register are discarded. No request is recorded and no grant is made.
- R3: A write with bit 1 set to offset 0 of locality n's window (n in 0..4) records an outstanding request for n. While the request is outstanding, bit 1 of n's register reads 1.
- R4: When no locality owns the interface and a request is outstanding, ownership is granted on the next clock edge. Bit 5 (active) then reads 1 in the owner's register only, and the owner's request bit clears.
- R5: When several requests are outstanding as the interface becomes free, the highest-numbered locality is granted first.
- R6: A write with bit 5 set to the owner's register frees the interface on that edge. A waiting request is granted on the following edge. Ownership never passes from one locality to another without a free cycle in between.
- R7: A release write from a locality that does not own the interface changes nothing. A request write from the current owner records no request.
- R8: Bit 2 (pending) of locality n's register reads 1 exactly when some locality other than n has an outstanding request.
- R9: `loc_change` is high for one cycle after every clock edge on which ownership is taken or released.
- R10: Writes to offsets other than 0, or to locality windows 5 to 7, are discarded. Reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Device initialization finished (sticky once seen) |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 15 | Locality in bits 14:12, offset in bits 11:0 |
| bus_wdata | input | 8 | Write data: bit 1 request, bit 5 release |
| bus_rdata | output | 8 | Ownership register of the addressed locality |
| loc_change | output | 1 | One-cycle owner-change event |

## Verification
The bench targets these corner cases:
- **Writes before initialization.** A design that let them through would grant an owner that software could never have validly requested.
- **Several requests outstanding at one release.** Picking the lowest locality, or an arbitrary one, would show up as a wrong active bit.
- **Release attempts from non-owners, and repeat requests from the owner.** A sloppy compare would drop the real owner or leave a stale request that re-grants the owner after it leaves.
- **Writes to non-zero offsets and to windows 5 to 7.** A decoder that ignores the upper bits would alias these writes onto valid localities.
- **A combined release-and-request write from the owner.** This checks that a locality cannot hand the interface back to itself.
- **The pending flag, seen from each locality.** This separates "another locality waits" from "this locality waits".

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_VALID  = 7;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_PEND   = 2;
  localparam int BIT_REQ    = 1;
endpackage

// File: rtl/loc_decode.sv
module loc_decode #(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12,
  localparam int LOC_W  = $clog2(NUM_LOC),
  localparam int ADDR_W = LOC_W + OFS_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic               ready,
  output logic [NUM_LOC-1:0] sel,
  output logic [NUM_LOC-1:0] wr_hit
);
  logic [LOC_W-1:0] loc_field;
  logic             ofs_zero;

  assign loc_field = addr[ADDR_W-1:OFS_W];
  assign ofs_zero  = (addr[OFS_W-1:0] == '0);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_win
    assign sel[i]    = ofs_zero && (loc_field == LOC_W'(i));
    assign wr_hit[i] = sel[i] && we && ready;
  end
endmodule

// File: rtl/loc_grant.sv
module loc_grant #(
  parameter int NUM_LOC = 5,
  localparam int LOC_W  = $clog2(NUM_LOC)
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [NUM_LOC-1:0] wr_hit,
  input  logic               wd_req,
  input  logic               wd_rel,
  output logic               own_v_q,
  output logic [LOC_W-1:0]   own_id_q,
  output logic [NUM_LOC-1:0] own_mask,
  output logic [NUM_LOC-1:0] req_q,
  output logic               chg_q
);
  logic               own_v_n;
  logic [LOC_W-1:0]   own_id_n;
  logic [NUM_LOC-1:0] req_n;
  logic               chg_n;
  logic               rel_hit;
  logic               grant;
  logic [LOC_W-1:0]   gid;
  logic [NUM_LOC-1:0] gmask;
  logic [NUM_LOC-1:0] req_set;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_mask
    assign own_mask[i] = own_v_q && (own_id_q == LOC_W'(i));
  end

  // Ascending scan: the last hit is the highest-numbered requester.
  always_comb begin
    gid = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req_q[i]) gid = LOC_W'(i);
    end
  end

  always_comb begin
    rel_hit  = wd_rel && |(wr_hit & own_mask);
    req_set  = wr_hit & {NUM_LOC{wd_req}} & ~own_mask;
    grant    = !own_v_q && |req_q;
    gmask    = grant ? (NUM_LOC'(1) << gid) : '0;
    own_v_n  = own_v_q ? !rel_hit : grant;
    own_id_n = grant ? gid : own_id_q;
    req_n    = (req_q | req_set) & ~gmask;
    chg_n    = rel_hit || grant;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      own_v_q  <= 1'b0;
      own_id_q <= '0;
      req_q    <= '0;
      chg_q    <= 1'b0;
    end else begin
      own_v_q  <= own_v_n;
      own_id_q <= own_id_n;
      req_q    <= req_n;
      chg_q    <= chg_n;
    end
  end
endmodule

// File: rtl/loc_readmux.sv
module loc_readmux
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic [NUM_LOC-1:0] sel,
  input  logic               ready,
  input  logic [NUM_LOC-1:0] own_mask,
  input  logic [NUM_LOC-1:0] req_q,
  output logic [REG_W-1:0]   rdata
);
  logic [REG_W-1:0] word [NUM_LOC];

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_word
    always_comb begin
      word[i]             = '0;
      word[i][BIT_VALID]  = ready;
      word[i][BIT_ACTIVE] = own_mask[i];
      word[i][BIT_PEND]   = |(req_q & ~(NUM_LOC'(1) << i));
      word[i][BIT_REQ]    = req_q[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (sel[i]) rdata = rdata | word[i];
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              init_done,
  input  logic                              bus_we,
  input  logic [$clog2(NUM_LOC)+OFS_W-1:0]  bus_addr,
  input  logic [7:0]                        bus_wdata,
  output logic [7:0]                        bus_rdata,
  output logic                              loc_change
);
  localparam int LOC_W = $clog2(NUM_LOC);

  logic [1:0]         rst_pipe;
  logic               arst_n;
  logic               ready_q;
  logic               ready_n;
  logic [NUM_LOC-1:0] sel;
  logic [NUM_LOC-1:0] wr_hit;
  logic               own_v_q;
  logic [LOC_W-1:0]   own_id_q;
  logic [NUM_LOC-1:0] own_mask;
  logic [NUM_LOC-1:0] req_q;
  logic               unused_wd;

  assign unused_wd = ^{bus_wdata[7:6], bus_wdata[4:2], bus_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  assign ready_n = ready_q | init_done;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ready_q <= 1'b0;
    else         ready_q <= ready_n;
  end

  loc_decode #(.NUM_LOC(NUM_LOC), .OFS_W(OFS_W)) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .ready  (ready_q),
    .sel    (sel),
    .wr_hit (wr_hit)
  );

  loc_grant #(.NUM_LOC(NUM_LOC)) u_grant (
    .clk      (clk),
    .arst_n   (arst_n),
    .wr_hit   (wr_hit),
    .wd_req   (bus_wdata[BIT_REQ]),
    .wd_rel   (bus_wdata[BIT_ACTIVE]),
    .own_v_q  (own_v_q),
    .own_id_q (own_id_q),
    .own_mask (own_mask),
    .req_q    (req_q),
    .chg_q    (loc_change)
  );

  loc_readmux #(.NUM_LOC(NUM_LOC)) u_rd (
    .sel      (sel),
    .ready    (ready_q),
    .own_mask (own_mask),
    .req_q    (req_q),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk #(
  parameter int NUM_LOC = 5,
  localparam int LOC_W  = $clog2(NUM_LOC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               own_v,
  input logic [LOC_W-1:0]   own_id,
  input logic [NUM_LOC-1:0] req,
  input logic               loc_chg
);
  // R2
  not_ready_no_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !own_v);

  // R4
  grant_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_v) |-> ($past(req) != '0));

  // R6
  no_direct_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && $past(own_v)) |-> (own_id == $past(own_id)));

  // R9
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v != $past(own_v)) |-> loc_chg);

  // R7
  owner_holds_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_v |-> ((req & (NUM_LOC'(1) << own_id)) == '0));
endmodule

bind loc_arbiter loc_arbiter_chk #(.NUM_LOC(NUM_LOC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ready   (ready_q),
  .own_v   (own_v_q),
  .own_id  (own_id_q),
  .req     (req_q),
  .loc_chg (loc_change)
);

// File: tb/tb_loc_arbiter.sv
module tb_loc_arbiter;
  localparam int NL = 5;
  localparam int OW = 12;
  localparam int AW = 3 + OW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_done;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;
  logic          loc_change;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur   = "R1";

  // reference model state
  bit       m_ready;
  int       m_own;
  bit [4:0] m_req;
  bit       m_chg;

  always #10 clk = ~clk;

  loc_arbiter dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .loc_change(loc_change)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 0; m_own = -1; m_req = '0; m_chg = 0;
    end else begin
      int loc, gid;
      bit ok, rel, grant;
      bit [4:0] setm, gmask;
      loc   = int'(bus_addr[AW-1:OW]);
      ok    = m_ready && bus_we && (bus_addr[OW-1:0] == '0) && (loc < NL);
      rel   = ok && bus_wdata[5] && (m_own == loc);
      setm  = '0;
      if (ok && bus_wdata[1] && (m_own != loc)) setm[loc] = 1'b1;
      grant = (m_own < 0) && (m_req != '0);
      gid   = -1;
      gmask = '0;
      if (grant) begin
        for (int i = NL - 1; i >= 0; i--) if (m_req[i] && gid < 0) gid = i;
        gmask[gid] = 1'b1;
      end
      m_chg = rel || grant;
      if (rel) m_own = -1;
      else if (grant) m_own = gid;
      m_req   = (m_req | setm) & ~gmask;
      m_ready = m_ready | init_done;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a);
    logic [7:0] r;
    int loc;
    r   = '0;
    loc = int'(a[AW-1:OW]);
    if (a[OW-1:0] == '0 && loc < NL) begin
      r[7] = m_ready;
      r[5] = (m_own == loc);
      r[2] = ((m_req & ~(5'b1 << loc)) != '0);
      r[1] = m_req[loc];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic we, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #5;
    chk(cur, int'(loc_change), int'(m_chg));
    chk(cur, int'(bus_rdata), int'(exp_rd(bus_addr)));
  endtask

  task automatic wrq(input int loc, input logic [7:0] d);
    drive(1'b1, AW'(loc) << OW, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_we = 1'b0;
      #2;
      chk(cur, int'(loc_change), int'(m_chg));
      for (int l = 0; l < NL; l++) begin
        bus_addr = AW'(l) << OW;
        #1;
        chk(cur, int'(bus_rdata), int'(exp_rd(bus_addr)));
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1..: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; init_done = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    cur = "R1"; idle(1);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    cur = "R2";
    wrq(2, 8'h02); idle(3);
    wrq(3, 8'h20); idle(2);

    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    cur = "R1"; idle(2);

    cur = "R3"; wrq(1, 8'h02); idle(1);
    cur = "R4"; idle(2);

    cur = "R8";
    wrq(0, 8'h02); wrq(4, 8'h02); wrq(3, 8'h02); idle(1);

    cur = "R7";
    wrq(1, 8'h02); idle(1);
    wrq(3, 8'h20); idle(1);
    wrq(2, 8'h20); idle(1);

    cur = "R6"; wrq(1, 8'h20); idle(3);
    cur = "R5";
    wrq(4, 8'h20); idle(2);
    wrq(3, 8'h20); idle(2);
    wrq(0, 8'h20); idle(2);

    cur = "R10";
    drive(1'b1, (AW'(2) << OW) | AW'(4), 8'h02);
    drive(1'b1, AW'(5) << OW, 8'h02);
    drive(1'b1, AW'(7) << OW, 8'h02);
    idle(2);
    drive(1'b0, (AW'(1) << OW) | AW'('h18), 8'h00);
    drive(1'b0, AW'(6) << OW, 8'h00);

    cur = "R9";
    wrq(2, 8'h02); idle(2);
    wrq(2, 8'h22); idle(2);
    wrq(0, 8'h02); wrq(1, 8'h02); idle(3);
    wrq(1, 8'h20); idle(3);
    wrq(0, 8'h20); idle(2);

    finish_run();
  end
endmodule